// File: doc/BRIEF.md
# Bus Value Seven-Segment Formatter

This block turns a 16-bit word taken from a parallel bus into a static picture on five seven-segment digits and one extra indicator LED. Two control pins select the number format. With the decimal pin low, the word is shown in hexadecimal. With the decimal pin high, the word is shown in decimal. In decimal mode a second pin decides whether the word is unsigned or two's complement. In the signed case, a negative value lights the extra LED as a minus sign and shows the magnitude.

The conversion is a pure combinational mapping from the word and the mode pins to the segment pattern. There is no processor, no iterative sequential arithmetic and no digit scanning, so the pattern settles a fixed logic delay after the input changes. The only register stage is a free-running brightness counter. Its comparison against a programmable duty value gates every segment and the minus LED together, which gives pulse-width dimming of the whole display.

Top module: `busdisp_top`

## Requirements
- R1: With `dec_mode` low, digit k (k = 0 rightmost to 3) shows bits [4k+3:4k] of `bus_word`, digit 4 is dark and `minus_o` is off. Digit k drives `seg_o[7k+6:7k]`.
- R2: With `dec_mode` high and `signed_mode` low, the word is shown as an unsigned decimal 0 to 65535. A digit of weight 10^k with k >= 1 is dark when the value is below 10^k. Digit 0 is always shown, so zero shows as a single 0.
- R3: With `dec_mode` and `signed_mode` both high, the word is two's complement. A negative value lights `minus_o` and shows its magnitude by the rules of R2, so 0x8000 shows 32768. A value that is not negative keeps `minus_o` off.
- R4: `signed_mode` has no effect while `dec_mode` is low.
- R5: Segments are active high, bit 0 = a through bit 6 = g. The glyph values in hex are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71. A dark digit is 00.
- R6: An 8-bit counter advances by one on every clock and wraps from 255 to 0. All of `seg_o` and `minus_o` are forced to 0 whenever the counter is not below `duty`. Over any 256 consecutive cycles, a fixed lit pattern is therefore visible for exactly `duty` cycles, and a duty of 0 keeps the display dark.
- R7: The segment pattern follows a change of `bus_word`, `dec_mode` or `signed_mode` within the same cycle, with no clock edge in between.
- R8: While `rst_n` is low, the counter is held at 0, so any nonzero duty shows the converted pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the brightness counter |
| rst_n | input | 1 | Asynchronous active-low reset of the counter |
| bus_word | input | 16 | Value to display |
| dec_mode | input | 1 | 1 = decimal, 0 = hexadecimal |
| signed_mode | input | 1 | In decimal mode, 1 = two's complement |
| duty | input | 8 | Brightness duty value |
| seg_o | output | 35 | Segment drives, 7 per digit, digit 0 in bits 6:0 |
| minus_o | output | 1 | Minus-sign indicator LED |

## Verification
The segment and minus outputs are combinational in the word and the mode pins. They are due in the same cycle as the stimulus, so the bench changes inputs a quarter nanosecond after a time step and samples half a nanosecond later, never across a clock edge. Gating depends on the counter value, which changes only at a rising edge. The bench keeps its own count of edges since reset and applies the duty comparison to that count in every expected value. All 65536 words are compared in each of the three formats, and brightness is measured by counting lit samples taken at falling edges over one full 256-cycle period.

// File: rtl/busdisp_pkg.sv
package busdisp_pkg;

  localparam int SEG_W = 7;
  localparam int NIB_W = 4;

  // One display position: a value nibble and a dark flag.
  typedef struct packed {
    logic             blank;
    logic [NIB_W-1:0] val;
  } digit_t;

  // Active-high glyphs, bit 0 = segment a .. bit 6 = segment g (R5).
  function automatic logic [SEG_W-1:0] glyph(input logic [NIB_W-1:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'h0:    g = 7'h3F;
      4'h1:    g = 7'h06;
      4'h2:    g = 7'h5B;
      4'h3:    g = 7'h4F;
      4'h4:    g = 7'h66;
      4'h5:    g = 7'h6D;
      4'h6:    g = 7'h7D;
      4'h7:    g = 7'h07;
      4'h8:    g = 7'h7F;
      4'h9:    g = 7'h6F;
      4'hA:    g = 7'h77;
      4'hB:    g = 7'h7C;
      4'hC:    g = 7'h39;
      4'hD:    g = 7'h5E;
      4'hE:    g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/busdisp_bin2bcd.sv
// Combinational shift-and-add-3 binary to BCD converter.
module busdisp_bin2bcd #(
  parameter int BIN_W  = 16,
  parameter int DIGITS = 5
) (
  input  logic [BIN_W-1:0]    bin_i,
  output logic [4*DIGITS-1:0] bcd_o
);

  localparam int BCD_W = 4 * DIGITS;
  localparam int ACC_W = BIN_W + BCD_W;

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    acc[BIN_W-1:0] = bin_i;
    for (int s = 0; s < BIN_W; s++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[BIN_W+4*d +: 4] >= 4'd5)
          acc[BIN_W+4*d +: 4] = acc[BIN_W+4*d +: 4] + 4'd3;
      end
      acc = acc << 1;
    end
  end

  assign bcd_o = acc[BIN_W +: BCD_W];

endmodule

// File: rtl/busdisp_digit_sel.sv
// Chooses the value and dark flag of each position for the active format.
module busdisp_digit_sel
  import busdisp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIGITS = 5
) (
  input  logic [DATA_W-1:0]       word_i,
  input  logic                    dec_i,
  input  logic [4*DIGITS-1:0]     bcd_i,
  output digit_t [DIGITS-1:0]     digits_o
);

  localparam int NIBS  = DATA_W / NIB_W;
  localparam int PAD_W = NIB_W * DIGITS;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(word_i);

  always_comb begin
    logic lead;
    lead = 1'b1;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      if (dec_i) begin
        // Leading-zero suppression, position 0 always visible (R2).
        digits_o[i].val = bcd_i[4*i +: 4];
        if (i == 0) digits_o[i].blank = 1'b0;
        else        digits_o[i].blank = lead && (bcd_i[4*i +: 4] == 4'd0);
        lead = digits_o[i].blank;
      end else begin
        // Hex: nibbles on the low positions, the rest dark (R1).
        digits_o[i].val   = padded[NIB_W*i +: NIB_W];
        digits_o[i].blank = (i >= NIBS);
      end
    end
  end

endmodule

// File: rtl/busdisp_pwm.sv
// Free-running brightness counter and duty comparator.
module busdisp_pwm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_i,
  output logic             on_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign on_o = (cnt_q < duty_i);

  // R6: counter advances by one each cycle
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R6: counter wraps to zero after its maximum
  a_r6_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |=> (cnt_q == '0));

  // R6: zero duty never enables the drive
  a_r6_zero_duty_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |-> !on_o);

endmodule

// File: rtl/busdisp_top.sv
module busdisp_top
  import busdisp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIGITS = 5,
  parameter int PWM_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         bus_word,
  input  logic                      dec_mode,
  input  logic                      signed_mode,
  input  logic [PWM_W-1:0]          duty,
  output logic [SEG_W*DIGITS-1:0]   seg_o,
  output logic                      minus_o
);

  localparam int OUT_W = SEG_W * DIGITS;

  logic                neg;
  logic [DATA_W-1:0]   mag;
  logic [4*DIGITS-1:0] bcd;
  digit_t [DIGITS-1:0] digits;
  logic [OUT_W-1:0]    raw_seg;
  logic                pwm_on;

  // Sign handling: only decimal signed mode looks at the top bit (R3, R4).
  assign neg = dec_mode && signed_mode && bus_word[DATA_W-1];
  assign mag = neg ? -bus_word : bus_word;

  busdisp_bin2bcd #(.BIN_W(DATA_W), .DIGITS(DIGITS)) u_bcd (
    .bin_i (mag),
    .bcd_o (bcd)
  );

  busdisp_digit_sel #(.DATA_W(DATA_W), .DIGITS(DIGITS)) u_sel (
    .word_i   (bus_word),
    .dec_i    (dec_mode),
    .bcd_i    (bcd),
    .digits_o (digits)
  );

  for (genvar g = 0; g < DIGITS; g++) begin : g_glyph
    assign raw_seg[SEG_W*g +: SEG_W] = digits[g].blank ? '0 : glyph(digits[g].val);
  end

  busdisp_pwm #(.CNT_W(PWM_W)) u_pwm (
    .clk    (clk),
    .rst_n  (rst_n),
    .duty_i (duty),
    .on_o   (pwm_on)
  );

  assign seg_o   = pwm_on ? raw_seg : '0;
  assign minus_o = pwm_on && neg;

  // R6: gate off means every drive is dark
  a_r6_gate_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |-> (seg_o == '0 && !minus_o));

  // R3, R4: minus only for a negative word in decimal signed mode
  a_r3_minus_source: assert property (@(posedge clk) disable iff (!rst_n)
    minus_o |-> (dec_mode && signed_mode && bus_word[DATA_W-1]));

  // R1: leftmost position dark in hex mode
  a_r1_hex_left_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_mode |-> (seg_o[SEG_W*(DIGITS-1) +: SEG_W] == '0));

  // R2: rightmost digit lit whenever the gate is on in decimal mode
  a_r2_digit0_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode && pwm_on) |-> (seg_o[SEG_W-1:0] != '0));

  // R2: a visible leftmost decimal digit is never a zero
  a_r2_no_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode && !digits[DIGITS-1].blank) |-> (digits[DIGITS-1].val != '0));

endmodule

// File: tb/busdisp_top_bench.sv
module busdisp_top_bench;
  timeunit 1ns;
  timeprecision 10ps;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_word;
  logic        dec_mode;
  logic        signed_mode;
  logic [7:0]  duty;
  logic [34:0] seg_o;
  logic        minus_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] mcnt;  // edges since reset, per R6/R8

  busdisp_top u_busdisp_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_word    (bus_word),
    .dec_mode    (dec_mode),
    .signed_mode (signed_mode),
    .duty        (duty),
    .seg_o       (seg_o),
    .minus_o     (minus_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt <= 8'd0;
    else        mcnt <= mcnt + 8'd1;
  end

  // R5 glyph table
  function automatic logic [6:0] ref_glyph(input int v);
    case (v)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F; 10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic [34:0] ref_pattern(input logic [15:0] w, input logic dec,
                                              input logic sgn, output logic neg);
    logic [34:0] p;
    int mag;
    int pw;
    p   = '0;
    neg = dec && sgn && w[15];
    if (!dec) begin
      for (int k = 0; k < 4; k++) p[7*k +: 7] = ref_glyph(int'(w[4*k +: 4]));
    end else begin
      mag = neg ? 65536 - int'(w) : int'(w);
      pw  = 1;
      for (int k = 0; k < 5; k++) begin
        if (k == 0 || mag >= pw) p[7*k +: 7] = ref_glyph((mag / pw) % 10);
        pw = pw * 10;
      end
    end
    return p;
  endfunction

  task automatic check_out(input string req);
    logic [34:0] e;
    logic        en;
    logic        on;
    e  = ref_pattern(bus_word, dec_mode, signed_mode, en);
    on = (mcnt < duty);
    if (!on) begin e = '0; en = 1'b0; end
    checks++;
    if (seg_o !== e || minus_o !== en) begin
      errors++;
      $display("FAIL %s: word=%h dec=%b sgn=%b seg=%h minus=%b expected seg=%h minus=%b",
               req, bus_word, dec_mode, signed_mode, seg_o, minus_o, e, en);
    end
  endtask

  task automatic check_eq(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: reset state
  task automatic t_reset;
    rst_n = 1'b0; bus_word = 16'h1234; dec_mode = 1'b0; signed_mode = 1'b0; duty = 8'd0;
    repeat (3) @(negedge clk);
    check_eq("R8 duty0 dark in reset", {minus_o, seg_o[33:0]} | 35'(seg_o[34]), 35'd0);
    duty = 8'd1;
    repeat (2) @(negedge clk);
    check_out("R8 counter held, pattern shown in reset");
    check_eq("R8 hex 1234 in reset", seg_o, {7'h00, 7'h06, 7'h5B, 7'h4F, 7'h66});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Every word in one format, one word per nanosecond, no edge crossed.
  task automatic t_sweep(input logic dec, input logic sgn, input string req);
    dec_mode = dec; signed_mode = sgn; duty = 8'd200;
    @(negedge clk);
    #0.25;
    for (int v = 0; v < 65536; v++) begin
      bus_word = 16'(v);
      #0.5;
      check_out(req);
      #0.5;
    end
  endtask

  task automatic t_corners;
    duty = 8'd255;
    @(negedge clk);
    if (mcnt == 8'd255) @(negedge clk);
    #1;
    dec_mode = 1'b1; signed_mode = 1'b1; bus_word = 16'h8000; #1;
    check_eq("R3 -32768 shows 32768", seg_o, {7'h4F, 7'h5B, 7'h07, 7'h7D, 7'h7F});
    check_eq("R3 minus lit for -32768", 35'(minus_o), 35'd1);
    bus_word = 16'hFFFF; #1;
    check_eq("R3 -1 shows 1", seg_o, {28'd0, 7'h06});
    bus_word = 16'h7FFF; #1;
    check_eq("R3 32767 no minus", {seg_o[34:1], minus_o}, {7'h4F, 7'h5B, 7'h07, 7'h7D, 6'h03, 1'b0});
    signed_mode = 1'b0; bus_word = 16'h0000; #1;
    check_eq("R2 zero single digit", seg_o, {28'd0, 7'h3F});
    bus_word = 16'd100; #1;
    check_eq("R2 100 three digits", seg_o, {14'd0, 7'h06, 7'h3F, 7'h3F});
    dec_mode = 1'b0; bus_word = 16'hABCD; #1;
    check_eq("R1 hex ABCD", seg_o, {7'h00, 7'h77, 7'h7C, 7'h39, 7'h5E});
    signed_mode = 1'b1; #1;
    check_eq("R4 signed ignored in hex", {seg_o[34:1], minus_o}, {7'h00, 7'h77, 7'h7C, 7'h39, 6'h2F, 1'b0});
    bus_word = 16'hF00E; #1;
    check_eq("R4 negative word in hex no minus", {seg_o[34:1], minus_o}, {7'h00, 7'h71, 7'h3F, 7'h3F, 6'h3C, 1'b0});
  endtask

  // R7: output follows an input change between two clock edges
  task automatic t_comb;
    duty = 8'd255;
    @(negedge clk);
    if (mcnt == 8'd255) @(negedge clk);
    dec_mode = 1'b1; signed_mode = 1'b0; bus_word = 16'd65535; #1;
    check_out("R7 first value");
    bus_word = 16'd7; #1;
    check_out("R7 changed word same cycle");
    dec_mode = 1'b0; #1;
    check_out("R7 changed mode same cycle");
  endtask

  // R6: lit samples over one full counter period equal duty
  task automatic t_duty(input logic [7:0] d);
    int lit;
    lit = 0;
    dec_mode = 1'b0; signed_mode = 1'b0; bus_word = 16'h0008; duty = d;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      if (seg_o != '0) lit++;
    end
    check_eq($sformatf("R6 lit cycles for duty %0d", d), 35'(lit), 35'(d));
  endtask

  initial begin
    t_reset;
    t_corners;
    t_comb;
    t_duty(8'd0);
    t_duty(8'd1);
    t_duty(8'd128);
    t_duty(8'd255);
    t_sweep(1'b0, 1'b0, "R1 R5 hex sweep");
    t_sweep(1'b1, 1'b0, "R2 R5 unsigned sweep");
    t_sweep(1'b1, 1'b1, "R3 R5 signed sweep");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule